// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces data-memory addresses for indirect loads and stores. It keeps four pointer registers. Each pointer has its own base and length register. The block also holds four shared modify registers and a page register. On every access the selected pointer is offset by a modify amount. That amount comes either from one of the modify registers or from a signed 8-bit immediate. The offset is folded back into the pointer's circular window whenever that pointer's length is nonzero.

An access runs in one of two modes. In pre-modify mode the offset pointer is sent out and the stored pointer is left untouched. In post-modify mode the old pointer is sent out and the offset value is written back. The emitted address is 24 bits wide. The page register supplies the top eight bits, and no pointer arithmetic ever carries into them.

Every register exists twice, once in a primary bank and once in a secondary bank. A one-bit bank select, registered inside the block, chooses which bank accesses use. This makes a context switch a single-cycle event. Software-side loading goes through one write port that names the register kind, the register number and the target bank.

Top module: `cbuf_agen`

## Requirements
- R1: After a synchronous reset every register in both banks is zero, the primary bank (0) is active, `addr_valid` is low and `addr_out` is zero.
- R2: An access with `acc_post`=1 emits `{page, old pointer}` and writes the wrapped sum of pointer and modify amount back into the pointer.
- R3: An access with `acc_post`=0 emits `{page, wrapped sum of pointer and modify amount}` and leaves the stored pointer unchanged.
- R4: With `acc_use_imm`=1 the modify amount is `acc_imm` read as an 8-bit two's-complement value and sign-extended to 16 bits. With `acc_use_imm`=0 it is the modify register numbered by `acc_mod_sel`, read as 16-bit two's complement.
- R5: When the pointer's length L is nonzero, let s = pointer + modify. The result is s − L if s ≥ base + L, s + L if s < base, and s otherwise. This keeps the pointer inside [base, base+L−1] whenever it starts there, |modify| < L and the window lies within one page.
- R6: When the pointer's length is zero, the result is pointer + modify taken modulo 2^16.
- R7: Bits 23:16 of `addr_out` always equal the active bank's page register as it stood before the access edge. Pointer arithmetic never changes them.
- R8: Writes land in the bank named by `wr_bank`, whichever bank is active. Accesses use the bank that `bank_sel` held at the previous clock edge, so a change of `bank_sel` affects accesses one cycle later.
- R9: A write uses `wr_kind` to pick the register kind: 0 pointer, 1 modify, 2 length, 3 base, 4 page. `wr_sel` picks register 0..3 and is ignored for the page. A written value is seen by an access in the following cycle.
- R10: If a register write and a post-modify writeback hit the same pointer in the same bank and cycle, the written value is kept. The access still emits the old pointer.
- R11: `addr_valid` is high for exactly the cycle after each access. In a cycle with no access, `addr_out` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Bank used by accesses from the next cycle on |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Register kind: 0 pointer, 1 modify, 2 length, 3 base, 4 page |
| wr_bank | input | 1 | Bank that the write targets |
| wr_sel | input | 2 | Register number within the kind |
| wr_data | input | 16 | Write value (low 8 bits used for the page) |
| acc_en | input | 1 | Access strobe |
| acc_post | input | 1 | 1 post-modify with writeback, 0 pre-modify without update |
| acc_ptr | input | 2 | Pointer used by the access |
| acc_use_imm | input | 1 | Take the modify amount from `acc_imm` |
| acc_mod_sel | input | 2 | Modify register used when `acc_use_imm` is 0 |
| acc_imm | input | 8 | Signed immediate modify amount |
| addr_out | output | 24 | Registered address `{page, offset}` |
| addr_valid | output | 1 | High the cycle after an access |

## Verification
Some properties are checked by assertions on every cycle:
- an offset that starts inside a nonzero-length window stays inside it;
- the page field matches the page register;
- a post-modify emits the untouched pointer;
- the address holds while idle;
- a register entry changes only through a write or a writeback, and a write always lands.

The exact wrapped values are shown only by the bench's sweeps over offsets for several window sizes, including a window that ends at 0xFFFF. The same applies to linear wraparound past 16 bits, the one-cycle delay of the bank select and the outcome of a write colliding with a writeback. All of these are compared against arithmetic done in the bench.

// File: rtl/cbag_pkg.sv
package cbag_pkg;
  typedef enum logic [2:0] {
    RK_INDEX  = 3'd0,
    RK_MODIFY = 3'd1,
    RK_LENGTH = 3'd2,
    RK_BASE   = 3'd3,
    RK_PAGE   = 3'd4
  } reg_kind_e;

  localparam int unsigned NBANK = 2;
endpackage

// File: rtl/cbag_rf.sv
module cbag_rf #(
  parameter int W    = 16,
  parameter int N    = 4,
  localparam int SW  = (N > 1) ? $clog2(N) : 1,
  localparam int AWR = SW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [SW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          upd_en,
  input  logic          upd_bank,
  input  logic [SW-1:0] upd_sel,
  input  logic [W-1:0]  upd_data,
  input  logic          rd_bank,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_data
);
  localparam int DEPTH = 2 * N;

  logic [W-1:0]   mem [DEPTH];
  logic [AWR-1:0] wa, ua, ra;

  assign wa = {wr_bank, wr_sel};
  assign ua = {upd_bank, upd_sel};
  assign ra = {rd_bank, rd_sel};

  // explicit write placed last so it wins over a writeback
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (upd_en) mem[ua] <= upd_data;
      if (wr_en)  mem[wa] <= wr_data;
    end
  end

  assign rd_data = mem[ra];

  // R9
  wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wa)] == $past(wr_data));

  // R2
  upd_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !(wr_en && wa == ua)) |=> mem[$past(ua)] == $past(upd_data));

  // R3
  no_touch_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !upd_en) |=> mem[$past(ra)] == $past(rd_data));
endmodule

// File: rtl/cbag_modsel.sv
module cbag_modsel #(
  parameter int AW   = 16,
  parameter int IMMW = 8
) (
  input  logic            use_imm,
  input  logic [IMMW-1:0] imm,
  input  logic [AW-1:0]   mreg,
  output logic [AW-1:0]   mod
);
  logic [AW-1:0] imm_ext;

  generate
    if (IMMW < AW) begin : g_ext
      assign imm_ext = {{(AW-IMMW){imm[IMMW-1]}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[AW-1:0];
    end
  endgenerate

  assign mod = use_imm ? imm_ext : mreg;
endmodule

// File: rtl/cbag_wrap.sv
module cbag_wrap #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] mod,
  output logic [AW-1:0] nxt
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] s_ptr, s_mod, s_base, s_len, s_top, s_sum, s_fix;
  logic [AW-1:0]        mod_mag;

  always_comb begin
    s_ptr  = {2'b00, ptr};
    s_mod  = {{2{mod[AW-1]}}, mod};
    s_base = {2'b00, base};
    s_len  = {2'b00, len};
    s_top  = s_base + s_len;
    s_sum  = s_ptr + s_mod;
    s_fix  = s_sum;
    if (len != '0) begin
      if (s_sum >= s_top)      s_fix = s_sum - s_len;
      else if (s_sum < s_base) s_fix = s_sum + s_len;
    end
    nxt = s_fix[AW-1:0];
  end

  assign mod_mag = mod[AW-1] ? (~mod + 1'b1) : mod;

  // R5
  win_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (len != '0 && ptr >= base && {1'b0, ptr} < ({1'b0, base} + {1'b0, len}) && mod_mag < len)
      |-> (nxt >= base && {1'b0, nxt} < ({1'b0, base} + {1'b0, len})));
endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen #(
  parameter int AW   = 16,
  parameter int PW   = 8,
  parameter int NPTR = 4,
  parameter int NMOD = 4,
  parameter int IMMW = 8,
  localparam int PSW  = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int MSW  = (NMOD > 1) ? $clog2(NMOD) : 1,
  localparam int SELW = (PSW > MSW) ? PSW : MSW,
  localparam int OUTW = PW + AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bank_sel,
  input  logic            wr_en,
  input  logic [2:0]      wr_kind,
  input  logic            wr_bank,
  input  logic [SELW-1:0] wr_sel,
  input  logic [AW-1:0]   wr_data,
  input  logic            acc_en,
  input  logic            acc_post,
  input  logic [PSW-1:0]  acc_ptr,
  input  logic            acc_use_imm,
  input  logic [MSW-1:0]  acc_mod_sel,
  input  logic [IMMW-1:0] acc_imm,
  output logic [OUTW-1:0] addr_out,
  output logic            addr_valid
);
  import cbag_pkg::*;

  localparam int NPK = 3;

  logic          act_bank;
  logic [PW-1:0] page_q [NBANK];
  logic [AW-1:0] prd [NPK];
  logic [AW-1:0] mreg_rd, mod_amt, nxt_val, addr_lo;
  logic          acc_upd;

  always_ff @(posedge clk) begin
    if (rst) act_bank <= 1'b0;
    else     act_bank <= bank_sel;
  end

  assign acc_upd = acc_en && acc_post;

  // pointer, length and base: one file per kind, all indexed by pointer number
  generate
    for (genvar g = 0; g < NPK; g++) begin : g_prf
      localparam logic [2:0] KCODE = (g == 0) ? 3'(RK_INDEX) :
                                     (g == 1) ? 3'(RK_LENGTH) : 3'(RK_BASE);
      cbag_rf #(.W(AW), .N(NPTR)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en && wr_kind == KCODE),
        .wr_bank  (wr_bank),
        .wr_sel   (wr_sel[PSW-1:0]),
        .wr_data  (wr_data),
        .upd_en   ((g == 0) ? acc_upd : 1'b0),
        .upd_bank (act_bank),
        .upd_sel  (acc_ptr),
        .upd_data (nxt_val),
        .rd_bank  (act_bank),
        .rd_sel   (acc_ptr),
        .rd_data  (prd[g])
      );
    end
  endgenerate

  cbag_rf #(.W(AW), .N(NMOD)) u_mrf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en && wr_kind == 3'(RK_MODIFY)),
    .wr_bank  (wr_bank),
    .wr_sel   (wr_sel[MSW-1:0]),
    .wr_data  (wr_data),
    .upd_en   (1'b0),
    .upd_bank (1'b0),
    .upd_sel  ('0),
    .upd_data ('0),
    .rd_bank  (act_bank),
    .rd_sel   (acc_mod_sel),
    .rd_data  (mreg_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBANK; b++) page_q[b] <= '0;
    end else if (wr_en && wr_kind == 3'(RK_PAGE)) begin
      page_q[wr_bank] <= wr_data[PW-1:0];
    end
  end

  cbag_modsel #(.AW(AW), .IMMW(IMMW)) u_msel (
    .use_imm (acc_use_imm),
    .imm     (acc_imm),
    .mreg    (mreg_rd),
    .mod     (mod_amt)
  );

  cbag_wrap #(.AW(AW)) u_wrap (
    .clk  (clk),
    .rst  (rst),
    .ptr  (prd[0]),
    .base (prd[2]),
    .len  (prd[1]),
    .mod  (mod_amt),
    .nxt  (nxt_val)
  );

  assign addr_lo = acc_post ? prd[0] : nxt_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= acc_en;
      if (acc_en) addr_out <= {page_q[act_bank], addr_lo};
    end
  end

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> $stable(addr_out));

  // R7
  page_fld_chk: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_out[OUTW-1:AW] == $past(page_q[act_bank]));

  // R2
  post_old_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_post) |=> addr_out[AW-1:0] == $past(prd[0]));
endmodule

// File: tb/sim_cbuf_agen.sv
module sim_cbuf_agen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_kind = '0;
  logic        wr_bank = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        acc_en = 1'b0;
  logic        acc_post = 1'b0;
  logic [1:0]  acc_ptr = '0;
  logic        acc_use_imm = 1'b0;
  logic [1:0]  acc_mod_sel = '0;
  logic [7:0]  acc_imm = '0;
  logic [23:0] addr_out;
  logic        addr_valid;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int m_idx [2][4];
  int m_mod [2][4];
  int m_len [2][4];
  int m_base[2][4];
  int m_page[2];
  int act = 0;

  always #(CLK_P/2) clk = ~clk;

  cbuf_agen u0 (
    .clk(clk), .rst(rst), .bank_sel(bank_sel),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_bank(wr_bank), .wr_sel(wr_sel), .wr_data(wr_data),
    .acc_en(acc_en), .acc_post(acc_post), .acc_ptr(acc_ptr), .acc_use_imm(acc_use_imm),
    .acc_mod_sel(acc_mod_sel), .acc_imm(acc_imm),
    .addr_out(addr_out), .addr_valid(addr_valid)
  );

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, actv, expv);
    end
  endtask

  function automatic int wrapf(input int p, input int m, input int b, input int l);
    int n = p + m;
    if (l == 0) return n & 16'hFFFF;
    if (n >= b + l) n -= l;
    else if (n < b) n += l;
    return n & 16'hFFFF;
  endfunction

  function automatic int mod_of(input bit use_imm, input int ms, input int imm);
    int v;
    if (use_imm) begin
      v = imm & 8'hFF;
      if (v >= 128) v -= 256;
    end else begin
      v = m_mod[act][ms];
      if (v >= 32768) v -= 65536;
    end
    return v;
  endfunction

  task automatic wreg(input int kind, input int bank, input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 3'(kind); wr_bank = bank[0]; wr_sel = 2'(sel); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
    case (kind)
      0: m_idx[bank][sel]  = data & 16'hFFFF;
      1: m_mod[bank][sel]  = data & 16'hFFFF;
      2: m_len[bank][sel]  = data & 16'hFFFF;
      3: m_base[bank][sel] = data & 16'hFFFF;
      default: m_page[bank] = data & 8'hFF;
    endcase
  endtask

  task automatic acc(input bit post, input int p, input bit use_imm, input int ms,
                     input int imm, input string req);
    int nxt, expv;
    nxt = wrapf(m_idx[act][p], mod_of(use_imm, ms, imm), m_base[act][p], m_len[act][p]);
    expv = (m_page[act] << 16) | (post ? m_idx[act][p] : nxt);
    @(negedge clk);
    acc_en = 1'b1; acc_post = post; acc_ptr = 2'(p); acc_use_imm = use_imm;
    acc_mod_sel = 2'(ms); acc_imm = 8'(imm);
    @(negedge clk);
    acc_en = 1'b0;
    chk(addr_valid === 1'b1, {req, " R11 valid"}, int'(addr_valid), 1);
    chk(addr_out === 24'(expv), req, int'(addr_out), expv);
    if (post) m_idx[act][p] = nxt;
  endtask

  // pre-modify by zero: brings the stored pointer out unchanged
  task automatic peek(input int p, input string req);
    acc(1'b0, p, 1'b1, 0, 0, req);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      m_page[b] = 0;
      for (int i = 0; i < 4; i++) begin
        m_idx[b][i] = 0; m_mod[b][i] = 0; m_len[b][i] = 0; m_base[b][i] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(addr_valid === 1'b0, "R1 valid", int'(addr_valid), 0);
    chk(addr_out === 24'h0, "R1 addr", int'(addr_out), 0);
    for (int p = 0; p < 4; p++) peek(p, "R1 pointer zero");

    // R6 linear, R4 immediate, R7 page, R9 writes
    wreg(4, 0, 0, 16'h3C);
    wreg(0, 0, 0, 16'hFFF0);
    for (int im = -128; im < 128; im += 7) begin
      acc(1'b1, 0, 1'b1, 0, im, "R6 R2 linear post");
      acc(1'b0, 0, 1'b1, 0, -im, "R3 R6 linear pre");
    end
    peek(0, "R3 pointer unchanged after pre");
    wreg(1, 0, 1, 16'h7FFF);
    wreg(1, 0, 2, 16'h8001);
    acc(1'b1, 0, 1'b0, 1, 0, "R4 modify reg positive");
    acc(1'b1, 0, 1'b0, 2, 0, "R4 modify reg negative");
    acc(1'b0, 0, 1'b0, 1, 0, "R4 R3 pre by reg");

    // R5 circular windows
    for (int c = 0; c < 4; c++) begin
      int b, l;
      b = (c == 0) ? 16'h0100 : (c == 1) ? 16'h0200 : (c == 2) ? 16'hFFF0 : 16'h1234;
      l = (c == 0) ? 5 : (c == 1) ? 7 : (c == 2) ? 16 : 1;
      wreg(3, 0, 1, b);
      wreg(2, 0, 1, l);
      wreg(0, 0, 1, b + (l / 2));
      wreg(1, 0, 3, l - 1);
      wreg(1, 0, 0, (1 - l) & 16'hFFFF);
      for (int m = 1 - l; m < l; m++) begin
        acc(1'b1, 1, 1'b1, 0, m, "R5 wrap post");
        peek(1, "R5 R2 writeback");
        acc(1'b0, 1, 1'b1, 0, -m, "R5 R3 wrap pre");
      end
      for (int k = 0; k < 3; k++) acc(1'b1, 1, 1'b0, 3, 0, "R5 R4 wrap by reg up");
      for (int k = 0; k < 3; k++) acc(1'b1, 1, 1'b0, 0, 0, "R5 R4 wrap by reg down");
      peek(1, "R5 in window");
    end

    // R8 banks
    wreg(4, 1, 0, 16'hA5);
    wreg(0, 1, 0, 16'h4000);
    wreg(1, 1, 0, 16'h0003);
    peek(0, "R8 write to inactive bank not seen");
    @(negedge clk);
    bank_sel = 1'b1;
    acc_en = 1'b1; acc_post = 1'b0; acc_ptr = 2'd0; acc_use_imm = 1'b1; acc_imm = 8'd0;
    @(negedge clk);
    acc_en = 1'b0;
    chk(addr_out === 24'((m_page[0] << 16) | m_idx[0][0]), "R8 switch delayed one cycle",
        int'(addr_out), (m_page[0] << 16) | m_idx[0][0]);
    act = 1;
    acc(1'b1, 0, 1'b0, 0, 0, "R8 R7 secondary bank post");
    peek(0, "R8 secondary pointer updated");
    @(negedge clk);
    bank_sel = 1'b0;
    @(negedge clk);
    act = 0;
    peek(0, "R8 primary bank intact");

    // R10 collision
    @(negedge clk);
    acc_en = 1'b1; acc_post = 1'b1; acc_ptr = 2'd0; acc_use_imm = 1'b1; acc_imm = 8'd5;
    wr_en = 1'b1; wr_kind = 3'd0; wr_bank = 1'b0; wr_sel = 2'd0; wr_data = 16'h0777;
    @(negedge clk);
    acc_en = 1'b0; wr_en = 1'b0;
    chk(addr_out === 24'((m_page[0] << 16) | m_idx[0][0]), "R10 old pointer emitted",
        int'(addr_out), (m_page[0] << 16) | m_idx[0][0]);
    m_idx[0][0] = 16'h0777;
    peek(0, "R10 write wins");

    // R11 idle hold
    @(negedge clk);
    chk(addr_valid === 1'b0, "R11 idle valid low", int'(addr_valid), 0);
    chk(addr_out === 24'((m_page[0] << 16) | 16'h0777), "R11 idle hold",
        int'(addr_out), (m_page[0] << 16) | 16'h0777);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule